// File: doc/BRIEF.md
# Keyed Configuration Port with Banked Device Registers

This block is the configuration front end of a multi-function I/O controller. The host reaches it through two byte ports: an index port at a base address and a data port at the next address up. The configuration space is closed after reset. The host opens it by writing the opening key byte to the index port twice in a row. It then writes a register number to the index port and reads or writes that register through the data port. A separate closing key, also written to the index port, shuts the space again.

The register space holds a device-select register, read-only identification bytes (a 16-bit device code, a revision byte and a 16-bit vendor code) and a window of per-device registers from index 0x30 upward. The device-select value picks which device's copy of that window a data-port access reaches. Accesses into the window are also sent to the surrounding logic as one-cycle read and write strobes. Each strobe carries the device number, the register index and the write data. A stub register bank inside the block stores the window for every device, so the block can be used without any real device behind it.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is closed (`cfg_open_o` = 0) and `host_rdata_o` is 0xFF. Once the space is opened, the index register reads 0x00 and the device-select register (index 0x07) reads 0x00.
- R2: The space opens only when two index-port writes in a row both carry 0x87. An index-port write of any other byte after a single 0x87 returns the sequence to its start. Data-port accesses do not affect the sequence.
- R3: While the space is open, an index-port write of 0xAA closes it on the next clock. That write does not change the index register.
- R4: While the space is closed, data-port reads and index-port reads return 0xFF. Data-port writes change no register and raise no strobe.
- R5: While the space is open, an index-port write of any byte other than 0xAA loads the index register, and an index-port read returns it. A data-port access reaches the register the index selects. Read data appears on `host_rdata_o` one clock after the read cycle and holds until the next read.
- R6: Index 0x07 is the device-select register. A data-port write stores the byte and a data-port read returns it.
- R7: Indices 0x20 and 0x21 read 0x07 and 0x04 (device code 0x0704, high byte at the lower index). Index 0x22 reads the revision byte (parameter, default 0x01). Indices 0x23 and 0x24 read 0x19 and 0x34 (vendor code 0x1934, high byte first). Writes to these indices change nothing.
- R8: Indices 0x30 up to 0x30+BANK_REGS-1 are stored separately for each device number below NUM_DEV, so device 0x06 and device 0x07 hold independent values at the same index. Every other index, and any banked index under a device number of NUM_DEV or more, reads 0x00.
- R9: A data-port write while the space is open, to an index of 0x30 or above, raises `bank_wr_o` for exactly the next clock. A data-port read under the same conditions raises `bank_rd_o` for the next clock. In that clock `bank_dev_o`, `bank_reg_o` and `bank_wdata_o` show the device select, the index and the written byte. The two strobes are never high together.
- R10: The index port is at parameter BASE (0x2E or 0x4E, default 0x2E) and the data port at BASE+1. Accesses to any other address change no state, and reads of other addresses return 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr_i | input | 16 | Host I/O address of the current cycle |
| host_wr_i | input | 1 | Host byte write in this cycle |
| host_rd_i | input | 1 | Host byte read in this cycle |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Read byte, valid the clock after a read |
| cfg_open_o | output | 1 | Configuration space is open |
| bank_wr_o | output | 1 | One-clock write strobe into the device window |
| bank_rd_o | output | 1 | One-clock read strobe into the device window |
| bank_dev_o | output | 8 | Device number for the strobe |
| bank_reg_o | output | 8 | Register index for the strobe |
| bank_wdata_o | output | 8 | Write byte for the strobe |

## Verification
The checker watches the rules that can be judged at any clock. It checks that the space opens only straight after an index-port write of the opening key and closes after the closing key. It also checks that closed-space and foreign-address reads return 0xFF, that no strobe follows a closed-space access, and that the two strobes are never high together. Only the directed scenarios can show that two keys in a row are needed and that a stray byte between them restarts the sequence. The same holds for showing that the closing key leaves the index untouched, that the identification bytes survive writes, and that each device keeps its own window contents.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam logic [7:0]  KEY_OPEN   = 8'h87;
    localparam logic [7:0]  KEY_CLOSE  = 8'hAA;
    localparam logic [7:0]  IDX_DEVSEL = 8'h07;
    localparam logic [7:0]  IDX_WINDOW = 8'h30;
    localparam logic [15:0] DEVICE_CODE = 16'h0704;
    localparam logic [15:0] VENDOR_CODE = 16'h1934;
    localparam logic [7:0]  IDLE_BYTE  = 8'hFF;

    typedef enum logic [1:0] {
        KS_SHUT = 2'd0,
        KS_HALF = 2'd1,
        KS_OPEN = 2'd2
    } key_state_t;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic       at_index;
        logic       at_data;
        logic [7:0] data;
    } host_req_t;

    typedef struct packed {
        logic       hit;
        logic [7:0] value;
    } id_reply_t;

    function automatic id_reply_t id_lookup(input logic [7:0] idx,
                                            input logic [7:0] rev);
        id_reply_t r;
        r.hit   = 1'b1;
        r.value = 8'h00;
        case (idx)
            8'h20:   r.value = DEVICE_CODE[15:8];
            8'h21:   r.value = DEVICE_CODE[7:0];
            8'h22:   r.value = rev;
            8'h23:   r.value = VENDOR_CODE[15:8];
            8'h24:   r.value = VENDOR_CODE[7:0];
            default: r.hit   = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       open_o
);
    key_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= KS_SHUT;
        end else if (key_wr) begin
            case (st_q)
                KS_SHUT: st_q <= (key_byte == KEY_OPEN) ? KS_HALF : KS_SHUT;
                KS_HALF: st_q <= (key_byte == KEY_OPEN) ? KS_OPEN : KS_SHUT;
                KS_OPEN: st_q <= (key_byte == KEY_CLOSE) ? KS_SHUT : KS_OPEN;
                default: st_q <= KS_SHUT;
            endcase
        end
    end

    assign open_o = (st_q == KS_OPEN);

endmodule

// File: rtl/sio_id_regs.sv
module sio_id_regs
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] REVISION = 8'h01
) (
    input  logic [7:0] idx,
    output logic       hit,
    output logic [7:0] value
);
    id_reply_t reply;

    always_comb begin
        reply = id_lookup(idx, REVISION);
        hit   = reply.hit;
        value = reply.value;
    end

endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank #(
    parameter int NUM_DEV   = 8,
    parameter int BANK_REGS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] dev,
    input  logic [7:0] off,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    localparam int         OFF_W   = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;
    localparam logic [7:0] DEV_LIM = 8'(NUM_DEV);
    localparam logic [7:0] OFF_LIM = 8'(BANK_REGS);

    logic                        in_range;
    logic [OFF_W-1:0]            cell_sel;
    logic [NUM_DEV-1:0][7:0]     dev_rd;

    assign in_range = (dev < DEV_LIM) && (off < OFF_LIM);
    assign cell_sel = off[OFF_W-1:0];

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        logic [7:0] cell_q [BANK_REGS];
        logic       sel;

        assign sel = we && in_range && (dev == 8'(d));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < BANK_REGS; i++) cell_q[i] <= 8'h00;
            end else if (sel) begin
                cell_q[cell_sel] <= wdata;
            end
        end

        assign dev_rd[d] = cell_q[cell_sel];
    end

    always_comb begin
        rdata = 8'h00;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (in_range && (dev == 8'(d))) rdata = dev_rd[d];
        end
    end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] BASE      = 16'h002E,
    parameter logic [7:0]  REVISION  = 8'h01,
    parameter int          NUM_DEV   = 8,
    parameter int          BANK_REGS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] host_addr_i,
    input  logic        host_wr_i,
    input  logic        host_rd_i,
    input  logic [7:0]  host_wdata_i,
    output logic [7:0]  host_rdata_o,
    output logic        cfg_open_o,
    output logic        bank_wr_o,
    output logic        bank_rd_o,
    output logic [7:0]  bank_dev_o,
    output logic [7:0]  bank_reg_o,
    output logic [7:0]  bank_wdata_o
);
    localparam logic [15:0] DATA_PORT = BASE + 16'd1;

    host_req_t  req;
    logic       open;
    logic [7:0] idx_q;
    logic [7:0] devsel_q;
    logic       id_hit;
    logic [7:0] id_val;
    logic [7:0] bank_rdata;
    logic       in_window;
    logic       win_wr;
    logic       win_rd;
    logic [7:0] rd_val;
    logic [7:0] rdata_q;
    logic       bwr_q, brd_q;
    logic [7:0] bdev_q, breg_q, bdat_q;

    always_comb begin
        req.wr       = host_wr_i;
        req.rd       = host_rd_i;
        req.at_index = (host_addr_i == BASE);
        req.at_data  = (host_addr_i == DATA_PORT);
        req.data     = host_wdata_i;
    end

    sio_key_fsm u_key (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (req.wr && req.at_index),
        .key_byte (req.data),
        .open_o   (open)
    );

    sio_id_regs #(.REVISION(REVISION)) u_id (
        .idx   (idx_q),
        .hit   (id_hit),
        .value (id_val)
    );

    assign in_window = (idx_q >= IDX_WINDOW);
    assign win_wr    = open && req.wr && req.at_data && in_window;
    assign win_rd    = open && req.rd && req.at_data && in_window;

    sio_dev_bank #(.NUM_DEV(NUM_DEV), .BANK_REGS(BANK_REGS)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (win_wr),
        .dev   (devsel_q),
        .off   (idx_q - IDX_WINDOW),
        .wdata (req.data),
        .rdata (bank_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q    <= 8'h00;
            devsel_q <= 8'h00;
        end else if (open && req.wr) begin
            if (req.at_index && req.data != KEY_CLOSE) idx_q <= req.data;
            if (req.at_data && idx_q == IDX_DEVSEL)    devsel_q <= req.data;
        end
    end

    always_comb begin
        if (!(req.at_index || req.at_data) || !open) rd_val = IDLE_BYTE;
        else if (req.at_index)                       rd_val = idx_q;
        else if (idx_q == IDX_DEVSEL)                rd_val = devsel_q;
        else if (id_hit)                             rd_val = id_val;
        else if (in_window)                          rd_val = bank_rdata;
        else                                         rd_val = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= IDLE_BYTE;
            bwr_q   <= 1'b0;
            brd_q   <= 1'b0;
            bdev_q  <= 8'h00;
            breg_q  <= 8'h00;
            bdat_q  <= 8'h00;
        end else begin
            if (req.rd) rdata_q <= rd_val;
            bwr_q <= win_wr;
            brd_q <= win_rd;
            if (win_wr || win_rd) begin
                bdev_q <= devsel_q;
                breg_q <= idx_q;
                bdat_q <= win_wr ? req.data : 8'h00;
            end
        end
    end

    assign host_rdata_o = rdata_q;
    assign cfg_open_o   = open;
    assign bank_wr_o    = bwr_q;
    assign bank_rd_o    = brd_q;
    assign bank_dev_o   = bdev_q;
    assign bank_reg_o   = breg_q;
    assign bank_wdata_o = bdat_q;

endmodule

// File: rtl/sio_cfg_checks.sv
module sio_cfg_checks #(
    parameter logic [15:0] BASE = 16'h002E
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] host_addr_i,
    input logic        host_wr_i,
    input logic        host_rd_i,
    input logic [7:0]  host_wdata_i,
    input logic [7:0]  host_rdata_o,
    input logic        cfg_open_o,
    input logic        bank_wr_o,
    input logic        bank_rd_o
);
    localparam logic [15:0] DPORT = BASE + 16'd1;

    // R1: first clock out of reset finds the space closed
    p_closed_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !cfg_open_o);

    // R2: opening only right after an index write of the opening key
    p_open_follows_key_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open_o) |->
            $past(host_wr_i && host_addr_i == BASE && host_wdata_i == 8'h87));

    // R3: closing key shuts the space on the next clock
    p_close_key_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_open_o && host_wr_i && host_addr_i == BASE && host_wdata_i == 8'hAA)
            |=> !cfg_open_o);

    // R4: closed-space data reads return the idle byte
    p_closed_read_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open_o && host_rd_i && host_addr_i == DPORT) |=> host_rdata_o == 8'hFF);

    // R4: no strobe follows an access made while closed
    p_closed_no_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg_open_o |=> (!bank_wr_o && !bank_rd_o));

    // R9: read and write strobes are exclusive
    p_strobe_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bank_wr_o, bank_rd_o}));

    // R10: reads of foreign addresses return the idle byte
    p_foreign_read_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (host_rd_i && host_addr_i != BASE && host_addr_i != DPORT)
            |=> host_rdata_o == 8'hFF);

endmodule

bind sio_cfg_port sio_cfg_checks #(.BASE(BASE)) u_checks (
    .clk          (clk),
    .rst          (rst),
    .host_addr_i  (host_addr_i),
    .host_wr_i    (host_wr_i),
    .host_rd_i    (host_rd_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .cfg_open_o   (cfg_open_o),
    .bank_wr_o    (bank_wr_o),
    .bank_rd_o    (bank_rd_o)
);

// File: tb/tb_sio_cfg_port.sv
module tb_sio_cfg_port;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] IDX = 16'h002E;
    localparam logic [15:0] DAT = 16'h002F;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] host_addr_i;
    logic        host_wr_i, host_rd_i;
    logic [7:0]  host_wdata_i, host_rdata_o;
    logic        cfg_open_o, bank_wr_o, bank_rd_o;
    logic [7:0]  bank_dev_o, bank_reg_o, bank_wdata_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    sio_cfg_port dut (
        .clk(clk), .rst(rst), .host_addr_i(host_addr_i),
        .host_wr_i(host_wr_i), .host_rd_i(host_rd_i),
        .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
        .cfg_open_o(cfg_open_o), .bank_wr_o(bank_wr_o), .bank_rd_o(bank_rd_o),
        .bank_dev_o(bank_dev_o), .bank_reg_o(bank_reg_o),
        .bank_wdata_o(bank_wdata_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr_i = a; host_wdata_i = d; host_wr_i = 1'b1;
        @(negedge clk);
        host_wr_i = 1'b0; host_addr_i = 16'h0000;
    endtask

    task automatic io_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr_i = a; host_rd_i = 1'b1;
        @(negedge clk);
        host_rd_i = 1'b0; host_addr_i = 16'h0000;
        d = host_rdata_o;
    endtask

    task automatic reg_rd(input logic [7:0] r, output logic [7:0] d);
        io_wr(IDX, r);
        io_rd(DAT, d);
    endtask

    task automatic unlock();
        io_wr(IDX, 8'h87);
        io_wr(IDX, 8'h87);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 closed after reset", 8'(cfg_open_o), 8'h00);
        chk("R1 rdata after reset", host_rdata_o, 8'hFF);
        io_rd(DAT, v);
        chk("R4 closed data read", v, 8'hFF);
        io_rd(IDX, v);
        chk("R4 closed index read", v, 8'hFF);
    endtask

    task automatic t_key_sequence();
        logic [7:0] v;
        io_wr(IDX, 8'h87);
        io_wr(IDX, 8'h55);
        io_wr(IDX, 8'h87);
        chk("R2 broken pair stays closed", 8'(cfg_open_o), 8'h00);
        io_wr(DAT, 8'h12);
        io_wr(IDX, 8'h87);
        chk("R2 data access does not break pair", 8'(cfg_open_o), 8'h01);
        io_rd(IDX, v);
        chk("R1 index zero after reset", v, 8'h00);
        reg_rd(8'h07, v);
        chk("R1 device select zero after reset", v, 8'h00);
    endtask

    task automatic t_ident();
        logic [7:0] v;
        reg_rd(8'h20, v); chk("R7 device code high", v, 8'h07);
        reg_rd(8'h21, v); chk("R7 device code low", v, 8'h04);
        reg_rd(8'h22, v); chk("R7 revision", v, 8'h01);
        reg_rd(8'h23, v); chk("R7 vendor code high", v, 8'h19);
        reg_rd(8'h24, v); chk("R7 vendor code low", v, 8'h34);
        io_wr(IDX, 8'h20); io_wr(DAT, 8'hAB);
        io_rd(DAT, v);     chk("R7 device code read-only", v, 8'h07);
        io_wr(IDX, 8'h24); io_wr(DAT, 8'h00);
        io_rd(DAT, v);     chk("R7 vendor code read-only", v, 8'h34);
        reg_rd(8'h10, v);  chk("R8 unused index reads zero", v, 8'h00);
        io_rd(IDX, v);     chk("R5 index readback", v, 8'h10);
    endtask

    task automatic t_banks();
        logic [7:0] v;
        io_wr(IDX, 8'h07); io_wr(DAT, 8'h07);
        io_rd(DAT, v);     chk("R6 device select readback", v, 8'h07);
        io_wr(IDX, 8'h30); io_wr(DAT, 8'h5A);
        chk("R9 write strobe", 8'(bank_wr_o), 8'h01);
        chk("R9 strobe device", bank_dev_o, 8'h07);
        chk("R9 strobe index", bank_reg_o, 8'h30);
        chk("R9 strobe data", bank_wdata_o, 8'h5A);
        @(negedge clk);
        chk("R9 write strobe one clock", 8'(bank_wr_o), 8'h00);
        io_wr(IDX, 8'h07); io_wr(DAT, 8'h06);
        io_wr(IDX, 8'h30); io_wr(DAT, 8'hC3);
        io_rd(DAT, v);     chk("R8 device 6 window", v, 8'hC3);
        chk("R9 read strobe", 8'(bank_rd_o), 8'h01);
        chk("R9 read strobe device", bank_dev_o, 8'h06);
        io_wr(IDX, 8'h07); io_wr(DAT, 8'h07);
        reg_rd(8'h30, v);  chk("R8 device 7 window kept", v, 8'h5A);
        reg_rd(8'h3F, v);  chk("R8 last window cell", v, 8'h00);
        io_wr(IDX, 8'h07); io_wr(DAT, 8'h09);
        io_wr(IDX, 8'h30); io_wr(DAT, 8'h77);
        io_rd(DAT, v);     chk("R8 out-of-range device reads zero", v, 8'h00);
        io_wr(IDX, 8'h07); io_wr(DAT, 8'h07);
        io_wr(IDX, 8'h30);
    endtask

    task automatic t_close();
        logic [7:0] v;
        io_wr(IDX, 8'hAA);
        chk("R3 closing key", 8'(cfg_open_o), 8'h00);
        io_rd(DAT, v);     chk("R4 closed data read after close", v, 8'hFF);
        io_wr(DAT, 8'h11);
        chk("R4 closed write no strobe", 8'(bank_wr_o), 8'h00);
        unlock();
        io_rd(IDX, v);     chk("R3 index kept across close", v, 8'h30);
        io_rd(DAT, v);     chk("R4 closed write ignored", v, 8'h5A);
    endtask

    task automatic t_foreign();
        logic [7:0] v;
        io_wr(IDX, 8'hAA);
        io_wr(16'h004E, 8'h87);
        io_wr(16'h004E, 8'h87);
        chk("R10 other base does not open", 8'(cfg_open_o), 8'h00);
        unlock();
        io_wr(16'h004E, 8'h22);
        io_rd(IDX, v);     chk("R10 foreign write ignored", v, 8'h30);
        io_rd(16'h004F, v); chk("R10 foreign read idle", v, 8'hFF);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; host_addr_i = 16'h0; host_wr_i = 1'b0;
        host_rd_i = 1'b0; host_wdata_i = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_key_sequence();
        t_ident();
        t_banks();
        t_close();
        t_foreign();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule